// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible register bank in front of a clock generation unit. It decodes a 4 KB window on a plain 32-bit bus (byte address, write enable, write data, combinational read data) and keeps the settings that the clock logic uses. These are a mode word, two post-divider words, two PLL settings (the main PLL and the system PLL), three clock-gate words and one power-management word. Every register has its own write mask and its own bits that are forced to one. One location always reads back as a fixed status constant. Every other location reads as zero.

The frequency calculator downstream recomputes its derived clocks only when told to. The bank raises `recalc_req` for one cycle after each write that changes how clocks are generated. It also raises it once right after reset is released, so the derived values are valid from power-up. A small state machine produces this request. Its states are `ST_BOOT` (the first cycle after reset), `ST_IDLE` (no request) and `ST_PULSE` (request high). Its transitions are:
- BOOT_TO_PULSE, which always happens on the first clock.
- IDLE_TO_PULSE, taken on a triggering write.
- PULSE_HOLD, taken on a triggering write while a pulse is in progress.
- PULSE_TO_IDLE, taken otherwise.

Top module: `clkctl_regbank`

## Requirements
- R1: The word index is the byte address shifted right by two, within a 12-bit byte address, so address bits 1:0 are ignored. The map is as follows:
  - word 0: mode
  - word 1: divider A
  - word 2: divider B
  - word 4: main PLL
  - word 6: system PLL
  - words 8, 9 and 10: gates 0, 1 and 2
  - word 23: power-management
- R2: A write to word 0 stores the write data ANDed with 0x3B6FDFFF, ORed with bit 26, so bit 26 always reads back as 1.
- R3: A write to word 1 stores the data ANDed with 0xFF9F3FFF. A write to word 2 stores the data unchanged.
- R4: Writes to words 4 and 6 store the data ANDed with 0xBFFF3FFF. The PLL fields sit at bits 29:26 (pre-divider), 25:16 (denominator), 13:10 (integer) and 9:0 (numerator).
- R5: The three gate words store the full 32-bit write data. Reading word 18 returns 0x00004040 whatever was written there.
- R6: Reading any word not listed in R1 or R5 returns 0. A write to such a word, or to word 23, changes no readable state.
- R7: Reset values are:
  - mode: 0x074B0B7B
  - divider A: 0xFF870B48
  - divider B: 0x49FCFE7F
  - main PLL: 0x04001800 (pre-divider 1, denominator 0, integer 6, numerator 0)
  - system PLL: 0x04043001 (pre-divider 1, denominator 4, integer 12, numerator 1)
  - each gate word: 0xFFFFFFFF
  - power-management: 0x80209828
- R8: A write to word 0, 1, 2, 4 or 6 makes `recalc_req` high in the clock cycle that follows the write edge. Back-to-back triggering writes keep it high.
- R9: `recalc_req` stays low after writes to the gate words, word 23, word 18, unmapped words, and after idle cycles. The one exception is the start-up pulse of R10. The request is low while reset is asserted.
- R10: `recalc_req` is high for exactly the first cycle after the first clock edge following reset release, even when no write occurs.
- R11: Reads are combinational from the stored state. A read of the word being written in the same cycle returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| recalc_req | output | 1 | One-cycle request to recompute derived frequencies |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- Mask boundaries: it writes all-ones and all-zeros to every register. A wrong mask or a missing forced bit 26 would leave a cleared bit set, or drop the forced one.
- Locations that look similar but behave differently: it writes to word 18, word 23, word 3 and the top of the window. A decoder that aliases, or that stores into the read-only power-management word, would show changed read data.
- Request timing: it covers the request immediately after reset, back-to-back triggering writes, and gate writes placed between them. An off-by-one or level-sensitive request would show a pulse in the wrong cycle, or a missing one.
- Read during write: it reads a word in the same cycle it is written. A bypassed read path would return the new data too early.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned WORD_W   = 10;
    localparam int unsigned NUM_REGS = 9;
    localparam int unsigned NUM_GATE = 3;

    localparam logic [WORD_W-1:0] STATUS_WORD = WORD_W'(18);
    localparam logic [DATA_W-1:0] STATUS_VAL  = 32'h0000_4040;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PULSE = 2'd2
    } req_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [DATA_W-1:0] rst_val;
        logic [DATA_W-1:0] wmask;
        logic [DATA_W-1:0] force1;
        logic              writable;
        logic              recalc;
    } reg_desc_t;

    function automatic logic [DATA_W-1:0] pll_pack(
        input int unsigned pre, input int unsigned den,
        input int unsigned intg, input int unsigned num);
        logic [DATA_W-1:0] v;
        v = '0;
        v[29:26] = 4'(pre);
        v[25:16] = 10'(den);
        v[13:10] = 4'(intg);
        v[9:0]   = 10'(num);
        return v;
    endfunction

    localparam logic [DATA_W-1:0] PLL_WMASK = 32'hBFFF_3FFF;

    function automatic reg_desc_t reg_desc(input int unsigned slot);
        reg_desc_t d;
        d = '{word: '0, rst_val: '0, wmask: '1, force1: '0,
              writable: 1'b1, recalc: 1'b0};
        case (slot)
            0: begin
                d.word = WORD_W'(0);  d.rst_val = 32'h074B_0B7B;
                d.wmask = 32'h3B6F_DFFF; d.force1 = 32'h0400_0000;
                d.recalc = 1'b1;
            end
            1: begin
                d.word = WORD_W'(1);  d.rst_val = 32'hFF87_0B48;
                d.wmask = 32'hFF9F_3FFF; d.recalc = 1'b1;
            end
            2: begin
                d.word = WORD_W'(2);  d.rst_val = 32'h49FC_FE7F;
                d.recalc = 1'b1;
            end
            3: begin
                d.word = WORD_W'(4);  d.rst_val = pll_pack(1, 0, 6, 0);
                d.wmask = PLL_WMASK;  d.recalc = 1'b1;
            end
            4: begin
                d.word = WORD_W'(6);  d.rst_val = pll_pack(1, 4, 12, 1);
                d.wmask = PLL_WMASK;  d.recalc = 1'b1;
            end
            5, 6, 7: begin
                d.word = WORD_W'(8 + slot - 5);
                d.rst_val = 32'hFFFF_FFFF;
            end
            default: begin
                d.word = WORD_W'(23); d.rst_val = 32'h8020_9828;
                d.writable = 1'b0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
    import clkctl_pkg::*;
(
    input  logic [WORD_W-1:0]   word,
    output logic [NUM_REGS-1:0] reg_hit,
    output logic                status_hit
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        localparam reg_desc_t D = reg_desc(i);
        assign reg_hit[i] = (word == D.word);
    end

    assign status_hit = (word == STATUS_WORD);
endmodule

// File: rtl/clkctl_field_reg.sv
module clkctl_field_reg
    import clkctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL  = '0,
    parameter logic [DATA_W-1:0] WMASK    = '1,
    parameter logic [DATA_W-1:0] FORCE1   = '0,
    parameter bit                WRITABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);
    if (WRITABLE) begin : g_rw
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= RST_VAL;
            else if (wr_en) q <= (wr_data & WMASK) | FORCE1;
        end
    end else begin : g_ro
        logic unused_wr;
        assign unused_wr = wr_en ^ (^wr_data);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= q;
        end
    end
endmodule

// File: rtl/clkctl_req_fsm.sv
module clkctl_req_fsm
    import clkctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic recalc_req
);
    req_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_PULSE;
            ST_IDLE:  state_d = trig ? ST_PULSE : ST_IDLE;
            ST_PULSE: state_d = trig ? ST_PULSE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        recalc_req = (state_q == ST_PULSE);
    end
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int unsigned ADDR_W = WORD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              recalc_req
);
    logic [WORD_W-1:0]               word;
    logic [1:0]                      unused_byte;
    logic [NUM_REGS-1:0]             reg_hit;
    logic                            status_hit;
    logic [NUM_REGS-1:0]             recalc_sel;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic                            trig;

    assign word        = bus_addr[ADDR_W-1:2];
    assign unused_byte = bus_addr[1:0];

    clkctl_decode u_decode (
        .word       (word),
        .reg_hit    (reg_hit),
        .status_hit (status_hit)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam reg_desc_t D = reg_desc(i);
        assign recalc_sel[i] = D.recalc;
        clkctl_field_reg #(
            .RST_VAL  (D.rst_val),
            .WMASK    (D.wmask),
            .FORCE1   (D.force1),
            .WRITABLE (D.writable)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_we & reg_hit[i]),
            .wr_data (bus_wdata),
            .q       (regs_q[i])
        );
    end

    assign trig = bus_we & (|(reg_hit & recalc_sel));

    clkctl_req_fsm u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .recalc_req (recalc_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (status_hit) bus_rdata = STATUS_VAL;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (reg_hit[i]) bus_rdata = regs_q[i];
        end
    end
endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk
    import clkctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] word,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              recalc_req,
    input logic [DATA_W-1:0] mode_q,
    input logic [DATA_W-1:0] diva_q,
    input logic [DATA_W-1:0] mpll_q,
    input logic [DATA_W-1:0] pm_q
);
    logic armed;
    logic trig_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign trig_w = bus_we && (word == 0 || word == 1 || word == 2 ||
                               word == 4 || word == 6);

    AST_MODE_BIT26: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && word == 0 |=> mode_q[26]); // R2
    AST_DIVA_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && word == 1 |=> (diva_q & ~32'hFF9F_3FFF) == 0); // R3
    AST_MPLL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && word == 4 |=> (mpll_q & ~32'hBFFF_3FFF) == 0); // R4
    AST_STATUS_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        word == 18 |-> bus_rdata == 32'h0000_4040); // R5
    AST_PM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && word == 23 |=> $stable(pm_q)); // R6
    AST_RECALC_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_w |=> recalc_req); // R8
    AST_NO_SPURIOUS_RECALC: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !trig_w |=> !recalc_req); // R9
    AST_BOOT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> recalc_req); // R10
endmodule

bind clkctl_regbank clkctl_regbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word       (word),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .recalc_req (recalc_req),
    .mode_q     (regs_q[0]),
    .diva_q     (regs_q[1]),
    .mpll_q     (regs_q[3]),
    .pm_q       (regs_q[8])
);

// File: tb/clkctl_regbank_tb_top.sv
`timescale 1ns/1ps
module clkctl_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        recalc_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mdl [int];
    bit          boot;
    bit          exp_req;
    string       req_tag;

    always #2.5 clk = ~clk;

    clkctl_regbank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .recalc_req (recalc_req)
    );

    function automatic logic [31:0] model_read(int w);
        if (w == 18) return 32'h0000_4040;
        if (mdl.exists(w)) return mdl[w];
        return 32'h0;
    endfunction

    function automatic bit model_trig(int w);
        return (w == 0 || w == 1 || w == 2 || w == 4 || w == 6);
    endfunction

    function automatic void model_reset();
        mdl.delete();
        mdl[0] = 32'h074B_0B7B; mdl[1] = 32'hFF87_0B48; mdl[2] = 32'h49FC_FE7F;
        mdl[4] = 32'h0400_1800; mdl[6] = 32'h0404_3001;
        mdl[8] = '1; mdl[9] = '1; mdl[10] = '1;
        mdl[23] = 32'h8020_9828;
    endfunction

    function automatic void model_write(int w, logic [31:0] d);
        case (w)
            0:        mdl[0] = (d & 32'h3B6F_DFFF) | 32'h0400_0000;
            1:        mdl[1] = d & 32'hFF9F_3FFF;
            2:        mdl[2] = d;
            4, 6:     mdl[w] = d & 32'hBFFF_3FFF;
            8, 9, 10: mdl[w] = d;
            default:  ;
        endcase
    endfunction

    function automatic void check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endfunction

    // one bus cycle: compare outputs, then let the model follow the clock edge
    task automatic op(bit we, int w, logic [31:0] d, string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_we    = we;
        bus_addr  = 12'((w << 2) | (w & 3));
        bus_wdata = d;
        #1;
        e = model_read(w);
        check(bus_rdata === e, we ? "R11" : tag, bus_rdata, e);
        check(recalc_req === exp_req, req_tag, {31'b0, recalc_req}, {31'b0, exp_req});
        @(posedge clk);
        if (!rst_n) begin
            exp_req = 0; req_tag = "R9"; boot = 1;
        end else begin
            exp_req = boot || (we && model_trig(w));
            req_tag = boot ? "R10" : ((we && model_trig(w)) ? "R8" : "R9");
            boot = 0;
            if (we) model_write(w, d);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        model_reset();
        boot = 1; exp_req = 0; req_tag = "R9";
        op(0, 0, 0, "R7");
        op(0, 1, 0, "R7");
        op(0, 2, 0, "R7");
        op(0, 4, 0, "R7");
        op(0, 6, 0, "R7");
        op(0, 8, 0, "R7");
        op(0, 9, 0, "R7");
        op(0, 10, 0, "R7");
        op(0, 23, 0, "R7");
        #1 rst_n = 1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        op(0, 18, 0, "R5");          // boot pulse observed after this cycle (R10)
        op(0, 3, 0, "R6");
        op(0, 1023, 0, "R6");
        // R2 mode masking and forced bit
        op(1, 0, 32'hFFFF_FFFF, "R2");
        op(0, 0, 0, "R2");
        op(1, 0, 32'h0000_0000, "R2");
        op(0, 0, 0, "R2");
        // R3 dividers
        op(1, 1, 32'hFFFF_FFFF, "R3");
        op(1, 2, 32'h1234_5678, "R3");
        op(0, 1, 0, "R3");
        op(0, 2, 0, "R3");
        // R4 PLL words, back-to-back triggers (R8)
        op(1, 4, 32'hFFFF_FFFF, "R4");
        op(1, 6, 32'hFFFF_FFFF, "R4");
        op(0, 4, 0, "R4");
        op(0, 6, 0, "R4");
        // R5 gate words, no request (R9)
        op(1, 8, 32'h0000_0000, "R5");
        op(1, 9, 32'hA5A5_5A5A, "R5");
        op(1, 10, 32'h0F0F_F0F0, "R5");
        op(0, 8, 0, "R5");
        op(0, 9, 0, "R5");
        op(0, 10, 0, "R5");
        // R6 ignored writes, R5 constant
        op(1, 23, 32'h0000_0000, "R6");
        op(1, 18, 32'hDEAD_BEEF, "R5");
        op(1, 3, 32'hFFFF_FFFF, "R6");
        op(1, 1023, 32'hFFFF_FFFF, "R6");
        op(0, 23, 0, "R6");
        op(0, 18, 0, "R5");
        op(0, 3, 0, "R6");
        op(0, 1023, 0, "R6");
        // R1 mixed traffic over the whole map
        for (int i = 0; i < 400; i++) begin
            int ws [15] = '{0, 1, 2, 3, 4, 5, 6, 8, 9, 10, 11, 18, 23, 24, 512};
            op(1'($urandom_range(0, 1)), ws[$urandom_range(0, 14)], $urandom, "R1");
        end
        // second reset: values and start-up pulse again (R7, R10)
        do_reset();
        op(0, 0, 0, "R7");
        op(0, 0, 0, "R9");
        op(0, 0, 0, "R9");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule